// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs external memory and I/O bus cycles for a 16-bit core. One set of pins is shared over time: it carries the address at the start of a cycle and the data for the rest of it. A separate 20-bit address bus carries the full address without multiplexing, and it changes half a clock before the shared pins do. The core raises a request with an address, a direction and write data. It gets back read data and a one-cycle completion strobe.

Each cycle steps through four states, T1 to T4. The third state repeats as a wait state until the combined ready is high. Ready comes from two inputs. One is asynchronous and is passed through a synchroniser chain first. The other is already synchronous to the bus clock. A configuration input can suppress the address phase on the shared pins. A bus-hold input stops new cycles from starting and releases the pins once the block is idle. While reset is asserted, the levels on the shared pins are captured into a read-only strap word that keeps its value after reset is released.

Pin three-state is modelled with output-enable signals.

Top module: `mux_bus_seq`

## Requirements
- R1: After a request is accepted, the block passes through T1, T2, T3 and T4 on successive clocks (T3 may repeat). In T1, `ad_out` carries the low 16 address bits. In T2 to T4, a write drives `wdata` with `ad_oe`=1 and a read leaves `ad_oe`=0. `bus_dir` is 1 during a write cycle.
- R2: `addr_bus` takes the new request address on the falling clock edge of the accepting cycle, half a clock before T1 begins. It does not change while a cycle is in progress.
- R3: `ale` is 1 during the first half of T1 and 0 from mid-T1 onward. The address is still on `ad_out` when `ale` falls.
- R4: With `aden_cfg`=0, `ad_oe` stays 0 throughout T1. The data phase is unaffected.
- R5: The combined ready is the synchronised `ardy_async` OR `srdy`, sampled at the end of each T3. While it is low, T3 repeats. With both ready inputs high, `done` arrives in the fourth clock after the accepting clock (zero waits).
- R6: `ardy_async` passes through SYNC_STAGES (default 2) flip-flops. A rise seen in clock c can end T3 no earlier than clock c+2. Holding `ardy_async` at 0 leaves `srdy` alone in control. A `srdy` rise in clock c can end T3 in that same clock c.
- R7: `done` is high for exactly one clock, during T4. For a read, `rdata` equals `ad_in` as sampled at the end of the last T3.
- R8: A request is accepted only when idle or in T4 (`req_ready`=1). A request pending in T4 starts its T1 on the very next clock.
- R9: While `hold_req` is 1, no new cycle starts and `req_ready` is 0. When idle under hold, `addr_oe`, `ad_oe` and `ale_oe` are 0.
- R10: While `rst` is 1, `addr_oe`, `ad_oe` and `ale_oe` are 0 and `ad_in` is loaded into `strap_cfg` every clock. After `rst` falls, `strap_cfg` holds the last captured value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core requests a bus cycle |
| req_addr | input | 20 | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request can be accepted this clock |
| done | output | 1 | One-clock completion strobe in T4 |
| rdata | output | 16 | Read data |
| addr_bus | output | 20 | Non-multiplexed address bus |
| addr_oe | output | 1 | Enable for addr_bus |
| ad_out | output | 16 | Multiplexed address/data drive value |
| ad_oe | output | 1 | Enable for ad_out |
| ad_in | input | 16 | Multiplexed pin levels |
| ale | output | 1 | Address latch enable strobe |
| ale_oe | output | 1 | Enable for ale |
| bus_dir | output | 1 | 1 while a write cycle is in progress |
| ardy_async | input | 1 | Asynchronous ready, active high |
| srdy | input | 1 | Synchronous ready, active high |
| hold_req | input | 1 | Bus-hold request |
| aden_cfg | input | 1 | 1 enables the address phase on ad_out |
| strap_cfg | output | 16 | Strap word captured during reset |

## Verification
The bench measures where `done` lands relative to the moment each ready input rises. A design without the synchroniser would finish two clocks early on the asynchronous path. One that sampled ready outside T3 would finish at the wrong clock on either path.

It samples `ale` on both sides of mid-T1 and checks `addr_bus` on the falling edge before T1. A strobe that stays high for the whole of T1, or an address bus updated on the rising edge, shows up as a mismatch.

The back-to-back case checks that a request waiting in T4 starts at once, and that no earlier acceptance moves the address bus in the middle of a cycle. The hold and reset cases check that the enables drop. They also check that the strap word does not follow the pins after reset, which a capture that never stops would do.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_T1   = 3'd1,
        ST_T2   = 3'd2,
        ST_T3   = 3'd3,
        ST_T4   = 3'd4
    } bus_state_t;

    function automatic logic in_data_phase(input bus_state_t s);
        return (s == ST_T2) || (s == ST_T3) || (s == ST_T4);
    endfunction

    function automatic logic in_cycle(input bus_state_t s);
        return s != ST_IDLE;
    endfunction

    function automatic logic can_accept(input bus_state_t s);
        return (s == ST_IDLE) || (s == ST_T4);
    endfunction

endpackage

// File: rtl/mbs_ready_sync.sv
module mbs_ready_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ardy_async,
    input  logic srdy,
    output logic rdy
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= 1'b0;
                    else     chain[0] <= ardy_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b0;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign rdy = chain[STAGES-1] | srdy;
endmodule

// File: rtl/mbs_seq_fsm.sv
module mbs_seq_fsm
    import mbs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [DATA_W-1:0] req_addr_lo,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              hold,
    input  logic              rdy,
    input  logic [DATA_W-1:0] ad_in,
    output bus_state_t        state,
    output logic              accept,
    output logic              eligible,
    output logic [DATA_W-1:0] lat_addr_lo,
    output logic              lat_write,
    output logic [DATA_W-1:0] lat_wdata,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    assign eligible = can_accept(state) && !hold;
    assign accept   = eligible && req_valid;
    assign done     = (state == ST_T4);

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            lat_addr_lo <= '0;
            lat_write   <= 1'b0;
            lat_wdata   <= '0;
            rdata       <= '0;
        end else begin
            if (accept) begin
                lat_addr_lo <= req_addr_lo;
                lat_write   <= req_write;
                lat_wdata   <= req_wdata;
            end
            unique case (state)
                ST_IDLE: if (accept) state <= ST_T1;
                ST_T1:   state <= ST_T2;
                ST_T2:   state <= ST_T3;
                ST_T3: begin
                    if (rdy) begin
                        state <= ST_T4;
                        if (!lat_write) rdata <= ad_in;
                    end
                end
                ST_T4:   state <= accept ? ST_T1 : ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/mbs_pad_drive.sv
module mbs_pad_drive
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              aden,
    input  bus_state_t        state,
    input  logic              accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] lat_addr_lo,
    input  logic              lat_write,
    input  logic [DATA_W-1:0] lat_wdata,
    output logic [ADDR_W-1:0] addr_bus,
    output logic              addr_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              ale,
    output logic              ale_oe,
    output logic              bus_dir
);
    logic ale_set;
    logic ale_clr;
    logic floating;

    // The separate address bus moves on the falling edge of the accepting clock.
    always_ff @(negedge clk) begin
        if (rst)         addr_bus <= '0;
        else if (accept) addr_bus <= req_addr;
    end

    // Strobe rises with T1 and is cleared by the following falling edge.
    always_ff @(posedge clk) begin
        if (rst) ale_set <= 1'b0;
        else     ale_set <= accept;
    end

    always_ff @(negedge clk) begin
        if (rst) ale_clr <= 1'b0;
        else     ale_clr <= ale_set;
    end

    assign floating = rst || (hold && (state == ST_IDLE));
    assign ale      = ale_set && !ale_clr && !rst;
    assign addr_oe  = !floating;
    assign ale_oe   = !floating;
    assign bus_dir  = in_cycle(state) && lat_write;

    always_comb begin
        ad_out = '0;
        ad_oe  = 1'b0;
        if (state == ST_T1) begin
            ad_out = lat_addr_lo;
            ad_oe  = aden;
        end else if (in_data_phase(state)) begin
            ad_out = lat_wdata;
            ad_oe  = lat_write;
        end
        if (floating) ad_oe = 1'b0;
    end
endmodule

// File: rtl/mbs_strap_capture.sv
module mbs_strap_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] pins,
    output logic [DATA_W-1:0] strap
);
    always_ff @(posedge clk) begin
        if (rst) strap <= pins;
    end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              done,
    output logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] addr_bus,
    output logic              addr_oe,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ale,
    output logic              ale_oe,
    output logic              bus_dir,
    input  logic              ardy_async,
    input  logic              srdy,
    input  logic              hold_req,
    input  logic              aden_cfg,
    output logic [DATA_W-1:0] strap_cfg
);
    bus_state_t        state_w;
    logic              rdy_w;
    logic              accept_w;
    logic [DATA_W-1:0] lat_addr_lo_w;
    logic              lat_write_w;
    logic [DATA_W-1:0] lat_wdata_w;

    mbs_ready_sync #(.STAGES(SYNC_STAGES)) u_rdy (
        .clk        (clk),
        .rst        (rst),
        .ardy_async (ardy_async),
        .srdy       (srdy),
        .rdy        (rdy_w)
    );

    mbs_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_addr_lo (req_addr[DATA_W-1:0]),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .hold        (hold_req),
        .rdy         (rdy_w),
        .ad_in       (ad_in),
        .state       (state_w),
        .accept      (accept_w),
        .eligible    (req_ready),
        .lat_addr_lo (lat_addr_lo_w),
        .lat_write   (lat_write_w),
        .lat_wdata   (lat_wdata_w),
        .done        (done),
        .rdata       (rdata)
    );

    mbs_pad_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pad (
        .clk         (clk),
        .rst         (rst),
        .hold        (hold_req),
        .aden        (aden_cfg),
        .state       (state_w),
        .accept      (accept_w),
        .req_addr    (req_addr),
        .lat_addr_lo (lat_addr_lo_w),
        .lat_write   (lat_write_w),
        .lat_wdata   (lat_wdata_w),
        .addr_bus    (addr_bus),
        .addr_oe     (addr_oe),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .ale         (ale),
        .ale_oe      (ale_oe),
        .bus_dir     (bus_dir)
    );

    mbs_strap_capture #(.DATA_W(DATA_W)) u_strap (
        .clk   (clk),
        .rst   (rst),
        .pins  (ad_in),
        .strap (strap_cfg)
    );
endmodule

// File: rtl/mbs_checker.sv
module mbs_checker
    import mbs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input bus_state_t        state,
    input logic              hold,
    input logic              rdy,
    input logic              done,
    input logic              ad_oe,
    input logic              addr_oe,
    input logic              ale_oe,
    input logic              aden,
    input logic              wr,
    input logic [DATA_W-1:0] strap_cfg
);
    a_r1_t1_to_t2: assert property (@(posedge clk) disable iff (rst)
        state == ST_T1 |=> state == ST_T2);

    a_r1_t2_to_t3: assert property (@(posedge clk) disable iff (rst)
        state == ST_T2 |=> state == ST_T3);

    a_r1_read_undriven: assert property (@(posedge clk) disable iff (rst)
        (in_data_phase(state) && !wr) |-> !ad_oe);

    a_r4_no_addr_phase: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T1 && !aden) |-> !ad_oe);

    a_r5_wait_repeats: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T3 && !rdy) |=> state == ST_T3);

    a_r5_ready_ends_t3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_T3 && rdy) |=> state == ST_T4);

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_hold_no_start: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && hold) |=> state == ST_IDLE);

    a_r9_hold_float: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && hold) |-> (!ad_oe && !addr_oe && !ale_oe));

    a_r10_strap_held: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(strap_cfg));

    always @(posedge clk) begin
        if (rst) begin
            a_r10_reset_float: assert (!ad_oe && !addr_oe && !ale_oe);
        end
    end
endmodule

bind mux_bus_seq mbs_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .state     (state_w),
    .hold      (hold_req),
    .rdy       (rdy_w),
    .done      (done),
    .ad_oe     (ad_oe),
    .addr_oe   (addr_oe),
    .ale_oe    (ale_oe),
    .aden      (aden_cfg),
    .wr        (lat_write_w),
    .strap_cfg (strap_cfg)
);

// File: tb/mux_bus_seq_test.sv
`timescale 1ns/1ps
module mux_bus_seq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        done;
    logic [15:0] rdata;
    logic [19:0] addr_bus;
    logic        addr_oe;
    logic [15:0] ad_out;
    logic        ad_oe;
    logic [15:0] ad_in = '0;
    logic        ale;
    logic        ale_oe;
    logic        bus_dir;
    logic        ardy_async = 1'b0;
    logic        srdy = 1'b0;
    logic        hold_req = 1'b0;
    logic        aden_cfg = 1'b1;
    logic [15:0] strap_cfg;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    mux_bus_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .addr_bus(addr_bus), .addr_oe(addr_oe),
        .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .ale(ale), .ale_oe(ale_oe),
        .bus_dir(bus_dir), .ardy_async(ardy_async), .srdy(srdy),
        .hold_req(hold_req), .aden_cfg(aden_cfg), .strap_cfg(strap_cfg)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // Step to 1 ns after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // One bus cycle. kind: 0 = ready already high, 1 = srdy rises in clock rel,
    // 2 = ardy_async rises in clock rel. Clock 0 is the accepting clock.
    task automatic run_cycle(input string tag, input logic wr, input logic [19:0] a,
                             input logic [15:0] wd, input logic [15:0] rv,
                             input int kind, input int rel);
        int exp_done;
        int seen = 0;
        if (kind == 0)      exp_done = 4;
        else if (kind == 1) exp_done = (rel + 1 > 4) ? rel + 1 : 4;
        else                exp_done = (rel + 3 > 4) ? rel + 3 : 4;
        if (kind != 0) begin
            srdy = 1'b0;
            ardy_async = 1'b0;
        end
        ad_in = rv;
        for (int c = 0; c <= exp_done + 1; c++) begin
            tick();
            if (c == 0) begin
                req_valid = 1'b1; req_addr = a; req_write = wr; req_wdata = wd;
            end
            if (c == 1) req_valid = 1'b0;
            if (kind == 1 && c == rel) srdy = 1'b1;
            if (kind == 2 && c == rel) ardy_async = 1'b1;
            if (c == 1) begin
                #1;
                chk(ale === 1'b1, {tag, " R3 ale high early T1"}, ale, 1);
                #5;
            end else begin
                #6;
            end
            if (c == 0) begin
                chk(addr_bus === a, {tag, " R2 addr_bus before T1"}, addr_bus, a);
                chk(req_ready === 1'b1, {tag, " R8 ready when idle"}, req_ready, 1);
            end
            if (c == 1) begin
                chk(ale === 1'b0, {tag, " R3 ale low after mid-T1"}, ale, 0);
                chk(ad_oe === aden_cfg, {tag, " R4 T1 ad_oe follows aden"}, ad_oe, aden_cfg);
                if (aden_cfg)
                    chk(ad_out === a[15:0], {tag, " R1 T1 address on ad"}, ad_out, a[15:0]);
            end
            if (c == 2) begin
                chk(ad_oe === wr, {tag, " R1 data phase ad_oe"}, ad_oe, wr);
                chk(bus_dir === wr, {tag, " R1 bus_dir"}, bus_dir, wr);
                if (wr) chk(ad_out === wd, {tag, " R1 write data"}, ad_out, wd);
                chk(addr_bus === a, {tag, " R2 addr_bus stable in cycle"}, addr_bus, a);
            end
            if (done === 1'b1) seen++;
            if (c == exp_done) begin
                chk(done === 1'b1, {tag, " R5 R6 done timing"}, done, 1);
                if (!wr) chk(rdata === rv, {tag, " R7 read data"}, rdata, rv);
            end else if (c >= 3) begin
                chk(done === 1'b0, {tag, " R5 R7 no done outside T4"}, done, 0);
            end
        end
        chk(seen == 1, {tag, " R7 single done pulse"}, seen, 1);
        ad_in = 16'h0;
    endtask

    task automatic t_reset();
        ad_in = 16'hA5C3;
        rst = 1'b1;
        repeat (3) begin
            tick();
            #6;
            chk(!addr_oe && !ad_oe && !ale_oe, "R10 enables low in reset",
                {addr_oe, ad_oe, ale_oe}, 0);
        end
        tick();
        rst = 1'b0;
        #2;
        ad_in = 16'h1234;
        tick();
        tick();
        #6;
        chk(strap_cfg === 16'hA5C3, "R10 strap held after reset", strap_cfg, 16'hA5C3);
        chk(addr_oe === 1'b1 && ale_oe === 1'b1, "R10 enables restored", {addr_oe, ale_oe}, 3);
        chk(done === 1'b0, "R7 done low after reset", done, 0);
    endtask

    task automatic t_zero_wait();
        srdy = 1'b1;
        ardy_async = 1'b0;
        aden_cfg = 1'b1;
        run_cycle("zero-wait write", 1'b1, 20'hABCDE, 16'h5A5A, 16'h0, 0, 0);
        srdy = 1'b0;
        ardy_async = 1'b1;
        repeat (3) tick();
        run_cycle("zero-wait read ardy", 1'b0, 20'h0F00F, 16'h0, 16'hC3E1, 0, 0);
    endtask

    task automatic t_srdy_waits();
        run_cycle("R6 srdy-only read", 1'b0, 20'h12345, 16'h0, 16'h7E81, 1, 6);
    endtask

    task automatic t_ardy_waits();
        run_cycle("R6 ardy sync read", 1'b0, 20'h54321, 16'h0, 16'h0FF0, 2, 4);
    endtask

    task automatic t_aden_off();
        aden_cfg = 1'b0;
        srdy = 1'b1;
        run_cycle("R4 no addr phase", 1'b1, 20'h33333, 16'hBEEF, 16'h0, 0, 0);
        aden_cfg = 1'b1;
    endtask

    task automatic t_back_to_back();
        srdy = 1'b1;
        tick();
        req_valid = 1'b1; req_addr = 20'h11111; req_write = 1'b1; req_wdata = 16'h1111;
        #6;
        tick();
        req_addr = 20'h22222; req_wdata = 16'h2222;
        #6;
        chk(addr_bus === 20'h11111, "R8 addr_bus not moved in T1", addr_bus, 20'h11111);
        tick();
        #6;
        chk(req_ready === 1'b0, "R8 not ready in T2", req_ready, 0);
        tick();
        #6;
        chk(addr_bus === 20'h11111, "R8 addr_bus not moved in T3", addr_bus, 20'h11111);
        tick();
        #6;
        chk(done === 1'b1 && req_ready === 1'b1, "R8 T4 accepts", {done, req_ready}, 3);
        chk(addr_bus === 20'h22222, "R8 R2 next address on falling edge in T4",
            addr_bus, 20'h22222);
        tick();
        req_valid = 1'b0;
        #1;
        chk(ale === 1'b1, "R8 back-to-back T1 strobe", ale, 1);
        #5;
        chk(ad_out === 16'h2222 && ad_oe === 1'b1, "R8 second address on ad", ad_out, 16'h2222);
        repeat (5) tick();
    endtask

    task automatic t_hold();
        tick();
        hold_req = 1'b1;
        req_valid = 1'b1; req_addr = 20'h44444; req_write = 1'b0;
        #6;
        chk(!addr_oe && !ad_oe && !ale_oe, "R9 idle hold floats", {addr_oe, ad_oe, ale_oe}, 0);
        chk(req_ready === 1'b0, "R9 not ready under hold", req_ready, 0);
        for (int i = 0; i < 4; i++) begin
            tick();
            #1;
            chk(ale === 1'b0 && done === 1'b0, "R9 no cycle under hold", {ale, done}, 0);
            #5;
        end
        tick();
        hold_req = 1'b0;
        req_valid = 1'b0;
        #6;
        chk(addr_oe === 1'b1 && ale_oe === 1'b1, "R9 drive after hold", {addr_oe, ale_oe}, 3);
        chk(addr_bus !== 20'h44444, "R9 held request never latched", addr_bus, 20'h44444);
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        t_reset();
        t_zero_wait();
        t_srdy_waits();
        t_ardy_waits();
        t_aden_off();
        t_back_to_back();
        t_hold();
        repeat (3) tick();
        summary();
    end
endmodule